// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block is the timing master for an interlaced standard-definition encoder. It advances once per pixel-clock enable, which normally pulses at half the master clock. It keeps a pixel position and a line number, and from them it derives the horizontal sync, the blanking flag and the field marker. There are two master personalities. In one, a FIELD level marks the even field. In the other, a VSYNC pulse encodes field parity through its phase against HSYNC: an odd field's pulse starts together with HSYNC, and an even field's pulse starts half a line later.

A standard-select input chooses a 525-line frame with 858-sample lines or a 625-line frame with 864-sample lines. The pixel-path side gets the registered line and pixel position, an active-video flag, and the 4:2:2 sample phase. The standard and mode inputs are sampled only at the first tick of a frame, so a change never produces a malformed frame. Vertical geometry is held in parameters, so a short test frame can be built with the same logic.

Top module: `vsg_top`

## Requirements
- R1: While reset is active, and until the first enabled tick, hs_n_o=1, vs_n_o=1, field_o=0, blank_n_o=0, comp_o=0, line_o=0 and pix_o=0.
- R2: Each enabled tick presents the next position on line_o/pix_o. pix_o runs from 0 to 857 (std_pal_i=0) or 0 to 863 (std_pal_i=1) and then wraps. line_o runs 1..525 or 1..625 and then wraps to 1. The first tick after reset shows line 1, pixel 0.
- R3: hs_n_o is low exactly when pix_o is 0 to 63.
- R4: On an active line, blank_n_o is high for pix_o 122..841 (525-line) or 132..851 (625-line), which is 720 samples. Otherwise it is low.
- R5: Active lines are 21..262 and 284..525 (525-line), and 23..310 and 336..623 (625-line). All other lines are blanked.
- R6: comp_o gives the 4:2:2 phase of the active sample as 0=Cb, 1=Y, 2=Cr, 3=Y. It is 0 on the first active sample of each line and counts modulo 4. It is 0 when blanked.
- R7: With mode 3'b101, vs_n_o falls at line 1 pixel 0, together with hs_n_o. It also falls at line 263 pixel 429 (525-line) or line 313 pixel 432 (625-line). Each pulse stays low for 3 lines (2574 ticks) or 2.5 lines (2160 ticks). field_o stays 0.
- R8: With any other mode value, field_o is 1 from line 263 (525-line) or 313 (625-line) to the end of the frame, and 0 otherwise. It changes only at pixel 0, while hs_n_o is low. vs_n_o stays 1.
- R9: std_pal_i and mode_i are sampled only on the tick at line 1 pixel 0. A change at any other time has no effect until the next frame starts.
- R10: While pix_en_i is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel tick enable |
| std_pal_i | input | 1 | 0 = 525-line, 1 = 625-line |
| mode_i | input | 3 | 3'b101 = VSYNC personality, other values = FIELD personality |
| hs_n_o | output | 1 | Horizontal sync, active low |
| vs_n_o | output | 1 | Vertical sync, active low |
| field_o | output | 1 | 1 during the even field |
| blank_n_o | output | 1 | High on active video samples |
| comp_o | output | 2 | 4:2:2 sample phase |
| line_o | output | 10 | Line number of the current outputs |
| pix_o | output | 10 | Pixel position of the current outputs |

## Verification
The hardest situation to reach is a standard or mode change that is requested mid-frame and must take effect only at the following frame boundary. This matters most when the line length changes across that boundary while a VSYNC pulse is still counting down. The bench shrinks the vertical geometry through parameters, so that whole frames fit in the run. It changes the inputs part-way through frames and gates the enable on every eighth cycle. A reference model runs tick by tick beside the design and compares every output on every cycle, including the cycles where the enable is low.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int PW = 10;
  localparam int LW = 10;
  localparam int VW = 13;

  typedef struct packed {
    logic [PW-1:0] line_pix;
    logic [PW-1:0] astart;
    logic [LW-1:0] lines;
    logic [LW-1:0] vbi;
    logic [LW-1:0] tail;
    logic [3:0]    vs_half;
  } std_t;
endpackage

// File: rtl/vsg_pos.sv
module vsg_pos
  import vsg_pkg::*;
#(
  parameter std_t T_N = '0,
  parameter std_t T_P = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pal_i,
  input  logic [2:0]    mode_i,
  output logic [PW-1:0] pix_o,
  output logic [LW-1:0] line_o,
  output std_t          cur_o,
  output logic          vmode_o
);
  logic [PW-1:0] pix_q;
  logic [LW-1:0] line_q;
  logic          pal_q, vm_q, frame_start, eff_pal;

  assign frame_start = (pix_q == '0) && (line_q == LW'(1));
  // configuration is taken live on the frame-start tick, held otherwise
  assign eff_pal = frame_start ? pal_i : pal_q;
  assign vmode_o = frame_start ? (mode_i == 3'b101) : vm_q;
  assign cur_o   = eff_pal ? T_P : T_N;
  assign pix_o   = pix_q;
  assign line_o  = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      line_q <= LW'(1);
      pal_q  <= 1'b0;
      vm_q   <= 1'b0;
    end else if (en_i) begin
      pal_q <= eff_pal;
      vm_q  <= vmode_o;
      if (pix_q == cur_o.line_pix - PW'(1)) begin
        pix_q  <= '0;
        line_q <= (line_q == cur_o.lines) ? LW'(1) : line_q + LW'(1);
      end else begin
        pix_q <= pix_q + PW'(1);
      end
    end
  end

  p_pix_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_q < cur_o.line_pix);
  p_line_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q >= LW'(1)) && (line_q <= cur_o.lines));
endmodule

// File: rtl/vsg_out.sv
module vsg_out
  import vsg_pkg::*;
#(
  parameter int HS_W    = 64,
  parameter int ACT_PIX = 720
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] pix_i,
  input  logic [LW-1:0] line_i,
  input  std_t          cur_i,
  input  logic          vmode_i,
  output logic          hs_n_o,
  output logic          vs_n_o,
  output logic          field_o,
  output logic          blank_n_o,
  output logic [1:0]    comp_o,
  output logic [LW-1:0] line_o,
  output logic [PW-1:0] pix_o
);
  logic [LW-1:0] even_l, odd_first, odd_last, even_first, even_last;
  logic [PW-1:0] half, rel;
  logic [VW-1:0] vs_len, vs_left;
  logic          act_line, act_pix, act, vs_evt;

  always_comb begin
    even_l     = (cur_i.lines + LW'(1)) >> 1;
    odd_first  = cur_i.vbi + LW'(1);
    odd_last   = even_l - LW'(1) - cur_i.tail;
    even_first = even_l + cur_i.vbi + LW'(1);
    even_last  = cur_i.lines - cur_i.tail;
    act_line   = ((line_i >= odd_first) && (line_i <= odd_last)) ||
                 ((line_i >= even_first) && (line_i <= even_last));
    act_pix    = (pix_i >= cur_i.astart) && (pix_i < cur_i.astart + PW'(ACT_PIX));
    act        = act_line && act_pix;
    rel        = pix_i - cur_i.astart;
    half       = cur_i.line_pix >> 1;
    vs_len     = VW'(cur_i.vs_half) * VW'(half);
    // odd field: with hsync; even field: mid-line
    vs_evt     = ((line_i == LW'(1)) && (pix_i == '0)) ||
                 ((line_i == even_l) && (pix_i == half));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_n_o    <= 1'b1;
      vs_n_o    <= 1'b1;
      field_o   <= 1'b0;
      blank_n_o <= 1'b0;
      comp_o    <= 2'd0;
      line_o    <= '0;
      pix_o     <= '0;
      vs_left   <= '0;
    end else if (en_i) begin
      hs_n_o    <= !(pix_i < PW'(HS_W));
      vs_left   <= vs_evt ? vs_len - VW'(1) :
                   (vs_left != '0) ? vs_left - VW'(1) : '0;
      vs_n_o    <= vmode_i ? !(vs_evt || (vs_left != '0)) : 1'b1;
      field_o   <= !vmode_i && (line_i >= even_l);
      blank_n_o <= act;
      comp_o    <= act ? rel[1:0] : 2'd0;
      line_o    <= line_i;
      pix_o     <= pix_i;
    end
  end

  p_blank_in_sync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_n_o |-> !blank_n_o);
  p_field_at_hs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_o) |-> !hs_n_o);
  p_vs_odd_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(vs_n_o) && !hs_n_o) |-> ((pix_o == '0) && (line_o == LW'(1))));
  p_cb_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blank_n_o) |-> (comp_o == 2'd0));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(hs_n_o) && $stable(vs_n_o) && $stable(pix_o) && $stable(line_o)));
endmodule

// File: rtl/vsg_top.sv
module vsg_top
  import vsg_pkg::*;
#(
  parameter int N_LINE_PIX = 858,
  parameter int N_LINES    = 525,
  parameter int N_ASTART   = 122,
  parameter int N_VBI      = 20,
  parameter int N_TAIL     = 0,
  parameter int N_VS_HALF  = 6,
  parameter int P_LINE_PIX = 864,
  parameter int P_LINES    = 625,
  parameter int P_ASTART   = 132,
  parameter int P_VBI      = 22,
  parameter int P_TAIL     = 2,
  parameter int P_VS_HALF  = 5,
  parameter int HS_W       = 64,
  parameter int ACT_PIX    = 720
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          std_pal_i,
  input  logic [2:0]    mode_i,
  output logic          hs_n_o,
  output logic          vs_n_o,
  output logic          field_o,
  output logic          blank_n_o,
  output logic [1:0]    comp_o,
  output logic [LW-1:0] line_o,
  output logic [PW-1:0] pix_o
);
  localparam std_t T_N = '{line_pix: PW'(N_LINE_PIX), astart: PW'(N_ASTART),
                           lines: LW'(N_LINES), vbi: LW'(N_VBI), tail: LW'(N_TAIL),
                           vs_half: 4'(N_VS_HALF)};
  localparam std_t T_P = '{line_pix: PW'(P_LINE_PIX), astart: PW'(P_ASTART),
                           lines: LW'(P_LINES), vbi: LW'(P_VBI), tail: LW'(P_TAIL),
                           vs_half: 4'(P_VS_HALF)};

  logic [PW-1:0] pix;
  logic [LW-1:0] line;
  std_t          cur;
  logic          vmode;

  vsg_pos #(.T_N(T_N), .T_P(T_P)) u_pos (
    .clk_i, .rst_ni, .en_i(pix_en_i), .pal_i(std_pal_i), .mode_i,
    .pix_o(pix), .line_o(line), .cur_o(cur), .vmode_o(vmode)
  );

  vsg_out #(.HS_W(HS_W), .ACT_PIX(ACT_PIX)) u_out (
    .clk_i, .rst_ni, .en_i(pix_en_i), .pix_i(pix), .line_i(line), .cur_i(cur),
    .vmode_i(vmode), .hs_n_o, .vs_n_o, .field_o, .blank_n_o, .comp_o, .line_o, .pix_o
  );
endmodule

// File: tb/vsg_top_tb.sv
module vsg_top_tb;
  localparam int CLK_P = 10;
  localparam int NL = 41, PL = 51, NV = 4, PV = 5;
  localparam int T_END = 123400;

  logic clk = 1'b0, rst_ni = 1'b0, pix_en = 1'b0, std_pal = 1'b0;
  logic [2:0] mode = 3'b101;
  logic hs_n, vs_n, field, blank_n;
  logic [1:0] comp;
  logic [9:0] line, pix;

  always #(CLK_P/2) clk = ~clk;

  vsg_top #(.N_LINES(NL), .P_LINES(PL), .N_VBI(NV), .P_VBI(PV)) u_dut (
    .clk_i(clk), .rst_ni, .pix_en_i(pix_en), .std_pal_i(std_pal), .mode_i(mode),
    .hs_n_o(hs_n), .vs_n_o(vs_n), .field_o(field), .blank_n_o(blank_n),
    .comp_o(comp), .line_o(line), .pix_o(pix)
  );

  typedef struct {int hs; int vs; int fld; int blk; int cmp; int ln; int px;} exp_t;
  exp_t q[$];
  exp_t last;
  int total = 0, bad = 0;
  int m_pix = 0, m_line = 1, m_pal = 0, m_vm = 0, m_vsl = 0;
  bit done = 0;

  task automatic chk(string tag, string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (line %0d pix %0d)",
               tag, nm, act, exp, m_line, m_pix);
    end
  endtask

  task automatic cmp_all(exp_t e, string hold);
    chk({hold, "R2"}, "pix", int'(pix), e.px);
    chk({hold, "R2"}, "line", int'(line), e.ln);
    chk({hold, "R3"}, "hs_n", int'(hs_n), e.hs);
    chk({hold, "R4/R5"}, "blank_n", int'(blank_n), e.blk);
    chk({hold, "R6"}, "comp", int'(comp), e.cmp);
    chk({hold, "R7"}, "vs_n", int'(vs_n), e.vs);
    chk({hold, "R8"}, "field", int'(field), e.fld);
  endtask

  // reference model: one enabled tick; R9 sampling at line 1 pixel 0
  task automatic model_tick(bit pal_in, logic [2:0] mode_in);
    exp_t e;
    int lp, lines, ast, vbi, tl, vh, ev, half, rel;
    bit act, evt;
    if (m_pix == 0 && m_line == 1) begin
      m_pal = int'(pal_in);
      m_vm  = (mode_in == 3'b101) ? 1 : 0;
    end
    lp    = m_pal ? 864 : 858;
    lines = m_pal ? PL : NL;
    ast   = m_pal ? 132 : 122;
    vbi   = m_pal ? PV : NV;
    tl    = m_pal ? 2 : 0;
    vh    = m_pal ? 5 : 6;
    ev    = (lines + 1) / 2;
    half  = lp / 2;
    act = (((m_line > vbi) && (m_line <= ev - 1 - tl)) ||
           ((m_line > ev + vbi) && (m_line <= lines - tl))) &&
          (m_pix >= ast) && (m_pix < ast + 720);
    rel   = m_pix - ast;
    evt   = (m_line == 1 && m_pix == 0) || (m_line == ev && m_pix == half);
    e.hs  = (m_pix < 64) ? 0 : 1;
    e.blk = act ? 1 : 0;
    e.cmp = act ? (rel % 4) : 0;
    e.fld = (!m_vm && m_line >= ev) ? 1 : 0;
    e.vs  = (m_vm && (evt || m_vsl != 0)) ? 0 : 1;
    m_vsl = evt ? vh * half - 1 : (m_vsl != 0 ? m_vsl - 1 : 0);
    e.ln  = m_line;
    e.px  = m_pix;
    q.push_back(e);
    if (m_pix == lp - 1) begin
      m_pix  = 0;
      m_line = (m_line == lines) ? 1 : m_line + 1;
    end else m_pix++;
  endtask

  initial begin
    int t = 0;
    bit prev_en = 0;
    last = '{hs: 1, vs: 1, fld: 0, blk: 0, cmp: 0, ln: 0, px: 0};
    repeat (3) @(negedge clk);
    cmp_all(last, "reset R1 ");
    rst_ni = 1'b1;
    @(negedge clk);
    cmp_all(last, "post-reset R1 ");
    for (int n = 0; t < T_END; n++) begin
      if (prev_en) begin
        last = q.pop_front();
        cmp_all(last, "");
      end else if (n > 0) begin
        cmp_all(last, "hold R10 ");
      end
      // R9: requests made mid-frame
      if (t == 20000)  begin std_pal = 1'b1; mode = 3'b011; end
      if (t == 50000)  mode = 3'b101;
      if (t == 100000) begin mode = 3'b010; std_pal = 1'b0; end
      pix_en = (n % 8 != 7);
      if (pix_en) begin
        model_tick(std_pal, mode);
        t++;
      end
      prev_en = pix_en;
      @(negedge clk);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule